// File: doc/BRIEF.md
# Flow-Control PAUSE Frame Generator

This block builds one 802.3x PAUSE frame whenever software asks for it. It sends the frame as a stream of bytes, one byte per clock, with valid, start and end markers. A later stage adds the preamble and the FCS, so neither is produced here. Each frame carries the reserved multicast destination, the station's own 48-bit address as the source, the MAC-control EtherType, the PAUSE opcode and the requested pause quanta. Zero bytes then pad the frame to the 60-byte minimum that applies before the FCS.

A request only counts when the link runs in full duplex with flow control switched on. The request is held in a pending flag, which is the command bit that software sees. The flag waits until the normal transmit path reports that it is idle, so the control frame is inserted only in the gap between ordinary packets. The station address and pause time are captured when the frame starts. When the last byte has gone out, a one-cycle done pulse is issued and the pending flag clears itself.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, `valid_o`, `sof_o`, `eof_o`, `done_o` and `pending_o` are low and `byte_o` is zero.
- R2: A `req_i` pulse sets `pending_o` only if `full_duplex_i` and `fc_enable_i` are both 1 in that cycle. Otherwise it is ignored: `pending_o` stays low and no frame is sent.
- R3: A frame starts on the first clock edge where `pending_o`, `tx_idle_i` and the mode enables are all high. `valid_o` rises in the next cycle. While `tx_idle_i` is low, a pending request waits with `valid_o` low.
- R4: Bytes 0 to 5 are 01, 80, C2, 00, 00, 01 (the reserved multicast destination).
- R5: Bytes 6 to 11 are the station address, most significant byte first. Bits 47:40 go out as byte 6.
- R6: Bytes 12 to 15 are 88, 08, 00, 01 (EtherType 0x8808, then opcode 0x0001).
- R7: Bytes 16 and 17 are the pause time, high byte first. Bytes 18 to 59 are zero.
- R8: `valid_o` stays high for exactly 60 consecutive cycles. `sof_o` is high only with byte 0 and `eof_o` only with byte 59.
- R9: `done_o` is high for exactly one cycle, the cycle right after `eof_o`. In that same cycle `pending_o` is low and `valid_o` is low.
- R10: The station address and pause time are sampled when the frame starts. Changing them during the frame does not change the bytes that are sent.
- R11: A request that arrives while a request is already pending, or while a frame is in progress, is merged with it. No second frame follows.
- R12: If full duplex or flow control drops while a request is pending and no frame has started, the request is cancelled: no frame and no done pulse. Once a frame has started, it completes even if the mode or `tx_idle_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Software request strobe |
| station_addr_i | input | 48 | Station address used as the source field |
| pause_time_i | input | 16 | Pause quanta placed in the frame |
| full_duplex_i | input | 1 | Link is in full-duplex mode |
| fc_enable_i | input | 1 | Flow control is enabled |
| tx_idle_i | input | 1 | Normal transmit path is between packets |
| byte_o | output | 8 | Frame byte |
| valid_o | output | 1 | `byte_o` holds a frame byte |
| sof_o | output | 1 | First byte of the frame |
| eof_o | output | 1 | Last byte of the frame |
| done_o | output | 1 | One-cycle pulse after the frame ends |
| pending_o | output | 1 | Command bit; clears itself at done |

## Verification
On every cycle, the bound checker checks the framing rules:
- the valid run is contiguous and 60 bytes long;
- start and end markers appear only with valid;
- the done pulse follows the end marker and is exactly one cycle long;
- the pending flag is clear at done;
- a frame starts only from a pending request while the transmitter is idle;
- a request made outside full duplex with flow control leaves pending low;
- the first byte is always 01.

The byte-by-byte contents can be shown only by the bench's scenarios, which sweep addresses and pause times, including the all-zero and all-one extremes. The same holds for the sampling at frame start, the merging of extra requests, and the cancel-before-start behaviour.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int ADDR_W = 48;
  localparam int TIME_W = 16;
  localparam int HDR_LEN = 18;
  localparam logic [47:0] RESERVED_DA = 48'h0180C2000001;
  localparam logic [15:0] CTRL_ETYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPC = 16'h0001;

  // Byte at position idx of the frame; positions past the header are padding.
  function automatic logic [7:0] frame_byte(input int idx,
                                            input logic [ADDR_W-1:0] sa,
                                            input logic [TIME_W-1:0] pt);
    logic [7:0] b;
    b = 8'h00;
    if (idx < 6)       b = RESERVED_DA[8*(5-idx) +: 8];
    else if (idx < 12) b = sa[8*(11-idx) +: 8];
    else if (idx < 14) b = CTRL_ETYPE[8*(13-idx) +: 8];
    else if (idx < 16) b = PAUSE_OPC[8*(15-idx) +: 8];
    else if (idx < 18) b = pt[8*(17-idx) +: 8];
    return b;
  endfunction
endpackage

// File: rtl/pause_cmd_latch.sv
module pause_cmd_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mode_ok,
  input  logic busy,
  input  logic finish,
  output logic pending
);
  logic pending_d;

  always_comb begin
    if (busy) pending_d = pending && !finish;
    else      pending_d = (pending || req) && mode_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pending_d;
  end
endmodule

// File: rtl/pause_frame_seq.sv
module pause_frame_seq
  import pause_pkg::*;
#(
  parameter int FRAME_LEN = 60,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] sa_in,
  input  logic [TIME_W-1:0] pt_in,
  output logic              busy,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] sa_q,
  output logic [TIME_W-1:0] pt_q,
  output logic              finish,
  output logic              done_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  assign finish = busy && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      sa_q   <= '0;
      pt_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        sa_q <= sa_in;
        pt_q <= pt_in;
      end else if (finish) begin
        busy <= 1'b0;
        idx  <= '0;
      end else if (busy) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [TIME_W-1:0] pause_time_i,
  input  logic              full_duplex_i,
  input  logic              fc_enable_i,
  input  logic              tx_idle_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              done_o,
  output logic              pending_o
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic              mode_ok_w;
  logic              start_w;
  logic              finish_w;
  logic              busy_w;
  logic              done_w;
  logic [IDX_W-1:0]  idx_w;
  logic [ADDR_W-1:0] sa_w;
  logic [TIME_W-1:0] pt_w;

  assign mode_ok_w = full_duplex_i && fc_enable_i;
  assign start_w   = pending_o && mode_ok_w && tx_idle_i && !busy_w;

  pause_cmd_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i),
    .mode_ok (mode_ok_w),
    .busy    (busy_w),
    .finish  (finish_w),
    .pending (pending_o)
  );

  pause_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_w),
    .sa_in  (station_addr_i),
    .pt_in  (pause_time_i),
    .busy   (busy_w),
    .idx    (idx_w),
    .sa_q   (sa_w),
    .pt_q   (pt_w),
    .finish (finish_w),
    .done_q (done_w)
  );

  assign valid_o = busy_w;
  assign sof_o   = busy_w && (idx_w == '0);
  assign eof_o   = finish_w;
  assign done_o  = done_w;
  assign byte_o  = busy_w ? frame_byte(int'(idx_w), sa_w, pt_w) : 8'h00;
endmodule

// File: rtl/pause_gen_chk.sv
module pause_gen_chk #(
  parameter int FRAME_LEN = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       full_duplex_i,
  input logic       fc_enable_i,
  input logic       tx_idle_i,
  input logic [7:0] byte_o,
  input logic       valid_o,
  input logic       sof_o,
  input logic       eof_o,
  input logic       done_o,
  input logic       pending_o
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_cnt <= '0;
    else if (valid_o && !eof_o) run_cnt <= run_cnt + 16'd1;
    else                       run_cnt <= '0;
  end

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> valid_o); // R8
  AST_EOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> valid_o); // R8
  AST_RUN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !eof_o) |=> valid_o); // R8
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> (run_cnt == 16'(FRAME_LEN - 1))); // R8
  AST_RISE_IS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> sof_o); // R8
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(tx_idle_i && pending_o)); // R3
  AST_DONE_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> (done_o && !valid_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_CLEARS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pending_o); // R9
  AST_REQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !pending_o && !valid_o && !(full_duplex_i && fc_enable_i)) |=> !pending_o); // R2
  AST_DA_LEAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (byte_o == 8'h01)); // R4
endmodule

bind pause_frame_gen pause_gen_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_i         (req_i),
  .full_duplex_i (full_duplex_i),
  .fc_enable_i   (fc_enable_i),
  .tx_idle_i     (tx_idle_i),
  .byte_o        (byte_o),
  .valid_o       (valid_o),
  .sof_o         (sof_o),
  .eof_o         (eof_o),
  .done_o        (done_o),
  .pending_o     (pending_o)
);

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int FLEN = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [47:0] station_addr_i = '0;
  logic [15:0] pause_time_i = '0;
  logic        full_duplex_i = 1'b1;
  logic        fc_enable_i = 1'b1;
  logic        tx_idle_i = 1'b1;
  logic [7:0]  byte_o;
  logic        valid_o, sof_o, eof_o, done_o, pending_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_frame_gen uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .station_addr_i(station_addr_i), .pause_time_i(pause_time_i),
    .full_duplex_i(full_duplex_i), .fc_enable_i(fc_enable_i), .tx_idle_i(tx_idle_i),
    .byte_o(byte_o), .valid_o(valid_o), .sof_o(sof_o), .eof_o(eof_o),
    .done_o(done_o), .pending_o(pending_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected frame image built as one header word, then padding.
  function automatic logic [7:0] exp_byte(input int i, input logic [47:0] sa, input logic [15:0] pt);
    logic [143:0] hdr;
    hdr = {48'h0180C2000001, sa, 16'h8808, 16'h0001, pt};
    if (i < 18) return hdr[8*(17-i) +: 8];
    return 8'h00;
  endfunction

  function automatic string field_tag(input int i);
    if (i < 6)  return "R4";
    if (i < 12) return "R5";
    if (i < 16) return "R6";
    return "R7";
  endfunction

  task automatic pulse_req();
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  // Watches for no frame activity over a window.
  task automatic expect_quiet(input string req, input int cycles);
    int seen_v = 0;
    int seen_d = 0;
    int seen_p = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      seen_v += int'(valid_o);
      seen_d += int'(done_o);
      seen_p += int'(pending_o);
    end
    check({req, " no valid"}, seen_v, 0);
    check({req, " no done"}, seen_d, 0);
    check({req, " pending low"}, seen_p, 0);
  endtask

  // Collects one frame; if disturb, changes inputs and re-requests mid-frame.
  task automatic recv_frame(input logic [47:0] sa, input logic [15:0] pt, input bit disturb);
    int wait_c = 0;
    while (!valid_o && wait_c < 100) begin
      @(negedge clk);
      wait_c++;
    end
    check("R3 frame began", valid_o, 1);
    for (int i = 0; i < FLEN; i++) begin
      check("R8 valid run", valid_o, 1);
      check(field_tag(i), byte_o, exp_byte(i, sa, pt));
      check("R8 sof", sof_o, (i == 0));
      check("R8 eof", eof_o, (i == FLEN - 1));
      if (disturb && i == 3) begin
        station_addr_i = ~sa;
        pause_time_i = ~pt;
        tx_idle_i = 1'b0;
        fc_enable_i = 1'b0;
      end
      if (disturb && i == 20) begin
        fc_enable_i = 1'b1;
        req_i = 1'b1;
      end
      if (disturb && i == 21) req_i = 1'b0;
      @(negedge clk);
    end
    check("R9 done after eof", done_o, 1);
    check("R9 valid low at done", valid_o, 0);
    check("R9 pending cleared", pending_o, 0);
    @(negedge clk);
    check("R9 done single", done_o, 0);
    tx_idle_i = 1'b1;
    fc_enable_i = 1'b1;
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] sa;
    logic [15:0] pt;
    repeat (3) @(negedge clk);
    check("R1 valid", valid_o, 0);
    check("R1 sof", sof_o, 0);
    check("R1 eof", eof_o, 0);
    check("R1 done", done_o, 0);
    check("R1 pending", pending_o, 0);
    check("R1 byte", byte_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of addresses and pause times, extremes included.
    for (int k = 0; k < 10; k++) begin
      if (k == 0)      begin sa = 48'h0;              pt = 16'h0; end
      else if (k == 1) begin sa = 48'hFFFF_FFFF_FFFF; pt = 16'hFFFF; end
      else begin
        sa = 48'h0102_0304_0506 * 48'(k) ^ {24'(k * 7919), 24'hA5C3E1};
        pt = 16'(k * 4099 + 3);
      end
      station_addr_i = sa;
      pause_time_i = pt;
      pulse_req();
      recv_frame(sa, pt, 1'b0);
      repeat (k % 3) @(negedge clk);
    end

    // R2: no full duplex.
    full_duplex_i = 1'b0;
    pulse_req();
    expect_quiet("R2 half duplex", 80);
    full_duplex_i = 1'b1;
    // R2: flow control off.
    fc_enable_i = 1'b0;
    pulse_req();
    expect_quiet("R2 fc off", 80);
    fc_enable_i = 1'b1;

    // R3: wait while the transmitter is busy, then go at the idle gap.
    tx_idle_i = 1'b0;
    sa = 48'h0A0B_0C0D_0E0F;
    pt = 16'h1234;
    station_addr_i = sa;
    pause_time_i = pt;
    pulse_req();
    repeat (12) @(negedge clk);
    check("R3 held pending", pending_o, 1);
    check("R3 no valid while busy", valid_o, 0);
    pulse_req(); // R11 second request while pending
    tx_idle_i = 1'b1;
    @(negedge clk);
    check("R3 valid one cycle after idle", valid_o, 1);
    recv_frame(sa, pt, 1'b0);
    expect_quiet("R11 merged while pending", 80);

    // R12: cancel before start.
    tx_idle_i = 1'b0;
    pulse_req();
    check("R12 pending set", pending_o, 1);
    fc_enable_i = 1'b0;
    @(negedge clk);
    fc_enable_i = 1'b1;
    tx_idle_i = 1'b1;
    expect_quiet("R12 cancelled", 80);

    // R10, R11, R12: disturbance during a frame.
    sa = 48'hC0FF_EE12_3456;
    pt = 16'hBEEF;
    station_addr_i = sa;
    pause_time_i = pt;
    pulse_req();
    recv_frame(sa, pt, 1'b1);
    expect_quiet("R11 merged during frame", 80);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule